// File: doc/BRIEF.md
# Keyed Configuration Stream Port

A memory-mapped slave through which boot firmware pulls configuration items out of the chip as byte streams. Software writes a 16-bit key into a write-only selector, then reads the selected item through a 64-bit data window. The window holds no stored value of its own. Each access moves the next 1, 2, 4 or 8 bytes of the item and advances a hidden per-item cursor by the access width.

Four items are built at elaboration time. Key 0 holds a four-character identifier. Key 1 holds the interface revision. Key 2 holds a computed read-only pattern. Key 3 is a writable scratch item that firmware can fill through the same window. Unknown keys behave as empty items. The register map is a 10-byte region: the data window sits at offsets 0x0 to 0x7 and the selector at 0x8 to 0x9. The size code on `bus_size` selects the access width as 1 << code bytes.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset, key 0 is selected and the cursor is 0. A write at offset 8 with size code 1 loads the key. `bus_wdata[7:0]` (the lower address) becomes the key's most significant byte and `bus_wdata[15:8]` its least significant byte. The cursor is cleared to 0. Selector writes with any other size code are ignored.
- R2: Reads at any offset other than 0, including the selector offsets 8 and 9, return zero and leave key and cursor unchanged. Writes at offsets 1 to 7 and 9 to 15 are ignored.
- R3: A read at offset 0 with width W = 1 << `bus_size` returns item byte cursor+j in lane j (`bus_rdata[8j+7:8j]`) for j < W. Lanes j >= W are zero. The cursor advances by W.
- R4: Bytes at positions at or past the item length, and all bytes of an unknown key, read as 0x00. The cursor never exceeds the item length; an advance that would pass the end stops at the length.
- R5: Key 0x0000 is a 4-byte item whose bytes in stream order are 0x43, 0x46, 0x47, 0x44.
- R6: Key 0x0001 is a 4-byte item holding the 32-bit revision in little-endian order (stream byte i = revision bits 8i+7:8i). The default revision is zero.
- R7: Key 0x0002 is a 12-byte read-only item whose byte i equals (0x10 + 3*i) mod 256.
- R8: Key 0x0003 is a 16-byte writable item, cleared by reset. A write at offset 0 stores lane j at position cursor+j for j < W and cursor+j below 16, then advances the cursor as a read would.
- R9: Data writes while a read-only or unknown key is selected change no item byte and leave the cursor unchanged.
- R10: When read and write strobes arrive together at offset 0 on key 3, the read returns the bytes as they stood before the access, the write stores its bytes, and the cursor advances by W exactly once.
- R11: `bus_rdata` is registered: it carries the read result in the cycle after the read strobe and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the region |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 2 | Access width code: 0=1, 1=2, 2=4, 3=8 bytes |
| bus_wdata | input | 64 | Write data, lane j = byte at offset j |
| bus_rdata | output | 64 | Registered read data, lane j = byte at offset j |

## Verification
A read and a write of the data window can land in the same cycle on the writable item. That one cycle then has to return the old bytes, store the new ones and move the cursor only once. The bench provokes this with combined strobes at several cursor positions, including one that straddles the item's end. A behavioural model predicts the outcome by applying the read before the write. The bench then reads the item back after reselection and compares the bytes, checking that the cursor moved once and not twice.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
  localparam int LANES = 8;

  localparam logic [15:0] KEY_SIG  = 16'h0000;
  localparam logic [15:0] KEY_REV  = 16'h0001;
  localparam logic [15:0] KEY_BLOB = 16'h0002;
  localparam logic [15:0] KEY_RW   = 16'h0003;

  localparam logic [3:0] OFS_DATA = 4'h0;
  localparam logic [3:0] OFS_SEL  = 4'h8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/keyed_cfg_ctrl.sv
module keyed_cfg_ctrl #(
  parameter int CUR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic [15:0]      sel_key,
  input  logic             adv,
  input  logic [3:0]       step,
  input  logic [CUR_W-1:0] len,
  output logic [15:0]      key_q,
  output logic [CUR_W-1:0] cur_q
);
  localparam int SW = CUR_W + 4;

  logic [SW-1:0] sum;
  assign sum = {4'b0, cur_q} + {{CUR_W{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      cur_q <= '0;
    end else if (sel_wr) begin
      key_q <= sel_key;
      cur_q <= '0;
    end else if (adv) begin
      cur_q <= (sum > {4'b0, len}) ? len : sum[CUR_W-1:0];
    end
  end
endmodule

// File: rtl/keyed_cfg_rom.sv
module keyed_cfg_rom
  import keyed_cfg_pkg::*;
#(
  parameter int          CUR_W     = 5,
  parameter logic [31:0] SIG_WORD  = 32'h4346_4744,
  parameter logic [31:0] REV_WORD  = 32'h0000_0000,
  parameter int          BLOB_LEN  = 12,
  parameter logic [7:0]  BLOB_SEED = 8'h10,
  parameter int          RW_LEN    = 16
) (
  input  logic [15:0]          key,
  input  logic [CUR_W-1:0]     cur,
  output logic [CUR_W-1:0]     item_len,
  output logic                 known,
  output logic                 writable,
  output logic [LANES*8-1:0]   rom_bytes
);
  localparam int IW = CUR_W + 4;

  function automatic logic [7:0] item_byte(input logic [15:0] k, input logic [IW-1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    if (k == KEY_SIG && idx < IW'(4)) begin
      case (idx[1:0])
        2'd0: b = SIG_WORD[31:24];
        2'd1: b = SIG_WORD[23:16];
        2'd2: b = SIG_WORD[15:8];
        default: b = SIG_WORD[7:0];
      endcase
    end else if (k == KEY_REV && idx < IW'(4)) begin
      b = REV_WORD[8*idx[1:0] +: 8];
    end else if (k == KEY_BLOB) begin
      b = BLOB_SEED + 8'(idx) * 8'd3;
    end
    return b;
  endfunction

  always_comb begin
    known    = 1'b1;
    writable = 1'b0;
    case (key)
      KEY_SIG:  item_len = CUR_W'(4);
      KEY_REV:  item_len = CUR_W'(4);
      KEY_BLOB: item_len = CUR_W'(BLOB_LEN);
      KEY_RW: begin
        item_len = CUR_W'(RW_LEN);
        writable = 1'b1;
      end
      default: begin
        item_len = '0;
        known    = 1'b0;
      end
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IW-1:0] idx;
    assign idx = IW'(cur) + IW'(j);
    assign rom_bytes[8*j +: 8] = item_byte(key, idx);
  end
endmodule

// File: rtl/keyed_cfg_ram.sv
module keyed_cfg_ram
  import keyed_cfg_pkg::*;
#(
  parameter int CUR_W = 5,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CUR_W-1:0]   cur,
  input  logic [LANES-1:0]   lane_we,
  input  logic [LANES*8-1:0] wdata,
  output logic [LANES*8-1:0] ram_bytes
);
  localparam int IW = CUR_W + 4;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] addr [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign addr[j] = IW'(cur) + IW'(j);
    assign ram_bytes[8*j +: 8] =
      (addr[j] < IW'(DEPTH)) ? mem[addr[j][AW-1:0]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      for (int j = 0; j < LANES; j++) begin
        if (lane_we[j] && addr[j] < IW'(DEPTH))
          mem[addr[j][AW-1:0]] <= wdata[8*j +: 8];
      end
    end
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter logic [31:0] SIG_WORD  = 32'h4346_4744,
  parameter logic [31:0] REV_WORD  = 32'h0000_0000,
  parameter int          BLOB_LEN  = 12,
  parameter logic [7:0]  BLOB_SEED = 8'h10,
  parameter int          RW_LEN    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_size,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata
);
  localparam int MAX_LEN = (BLOB_LEN > RW_LEN) ? ((BLOB_LEN > 4) ? BLOB_LEN : 4)
                                               : ((RW_LEN > 4) ? RW_LEN : 4);
  localparam int CUR_W   = $clog2(MAX_LEN + 1);
  localparam int IW      = CUR_W + 4;

  logic [15:0]        key_q;
  logic [CUR_W-1:0]   cur_q;
  logic [CUR_W-1:0]   item_len;
  logic               known, writable;
  logic [LANES*8-1:0] rom_bytes, ram_bytes;
  logic [LANES-1:0]   lane_we;
  logic [LANES*8-1:0] rdata_nxt;
  logic [3:0]         step;
  logic               data_hit, sel_wr, data_rd, data_wr, adv;

  assign step     = size_bytes(bus_size);
  assign data_hit = (bus_addr == OFS_DATA);
  assign sel_wr   = bus_wr && (bus_addr == OFS_SEL) && (bus_size == SZ_HALF);
  assign data_rd  = bus_rd && data_hit;
  assign data_wr  = bus_wr && data_hit && writable;
  assign adv      = known && (data_rd || data_wr);

  keyed_cfg_ctrl #(.CUR_W(CUR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sel_wr  (sel_wr),
    .sel_key ({bus_wdata[7:0], bus_wdata[15:8]}),
    .adv     (adv),
    .step    (step),
    .len     (item_len),
    .key_q   (key_q),
    .cur_q   (cur_q)
  );

  keyed_cfg_rom #(
    .CUR_W     (CUR_W),
    .SIG_WORD  (SIG_WORD),
    .REV_WORD  (REV_WORD),
    .BLOB_LEN  (BLOB_LEN),
    .BLOB_SEED (BLOB_SEED),
    .RW_LEN    (RW_LEN)
  ) u_rom (
    .key       (key_q),
    .cur       (cur_q),
    .item_len  (item_len),
    .known     (known),
    .writable  (writable),
    .rom_bytes (rom_bytes)
  );

  keyed_cfg_ram #(.CUR_W(CUR_W), .DEPTH(RW_LEN)) u_ram (
    .clk       (clk),
    .rst       (rst),
    .cur       (cur_q),
    .lane_we   (lane_we),
    .wdata     (bus_wdata),
    .ram_bytes (ram_bytes)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic lane_on, in_rng;
    logic [7:0] src;
    assign lane_on = (4'(j) < step);
    assign in_rng  = (IW'(cur_q) + IW'(j)) < IW'(item_len);
    assign src     = writable ? ram_bytes[8*j +: 8] : rom_bytes[8*j +: 8];
    assign lane_we[j] = data_wr && lane_on && in_rng;
    assign rdata_nxt[8*j +: 8] = (data_rd && lane_on && in_rng) ? src : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rdata_nxt;
  end
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
  parameter int CUR_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_size,
  input logic [63:0]      bus_rdata,
  input logic [15:0]      key,
  input logic [CUR_W-1:0] cur,
  input logic [CUR_W-1:0] len
);
  // R11: no read strobe, no data next cycle
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 64'h0);

  // R2: reads away from offset 0 return zero
  a_r2_offset_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != 4'h0) |=> bus_rdata == 64'h0);

  // R3: lanes above the access width stay zero
  a_r3_byte_lanes: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_size == 2'd0) |=> bus_rdata[63:8] == 56'h0);
  a_r3_half_lanes: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_size == 2'd1) |=> bus_rdata[63:16] == 48'h0);
  a_r3_word_lanes: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_size == 2'd2) |=> bus_rdata[63:32] == 32'h0);

  // R1: selecting clears the cursor
  a_r1_cursor_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h8 && bus_size == 2'd1) |=> cur == '0);

  // R4: cursor bounded by item length
  a_r4_cursor_bound: assert property (@(posedge clk) disable iff (rst)
    cur <= len);

  // R9: writes to read-only or unknown items leave the cursor alone
  a_r9_ro_write_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == 4'h0 && key != 16'h0003) |=> $stable(cur));

  // R2: idle bus changes no state
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd && !bus_wr) |=> ($stable(cur) && $stable(key)));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(.CUR_W(CUR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_size  (bus_size),
  .bus_rdata (bus_rdata),
  .key       (key_q),
  .cur       (cur_q),
  .len       (item_len)
);

// File: tb/keyed_cfg_port_tb.sv
module keyed_cfg_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int          m_key = 0;
  int          m_cur = 0;
  logic [7:0]  m_mem [16];
  logic [63:0] exp_q = '0;
  string       tag_q = "R11";

  always #5 clk = ~clk;

  keyed_cfg_port u_dut (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_size (bus_size), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic int m_len(input int k);
    case (k)
      0, 1:    return 4;
      2:       return 12;
      3:       return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] m_byte(input int k, input int i);
    logic [7:0] sig [4] = '{8'h43, 8'h46, 8'h47, 8'h44};
    case (k)
      0:       return sig[i];
      1:       return 8'h00;
      2:       return 8'(16 + 3 * i);
      default: return m_mem[i];
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: check the previous result, drive, advance the model
  task automatic cyc(input logic [3:0] a, input bit r, input bit w,
                     input logic [1:0] s, input logic [63:0] d, input string tag);
    int wbytes, len;
    logic [63:0] e;
    @(negedge clk);
    check(tag_q, bus_rdata, exp_q);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_size = s; bus_wdata = d;
    e = '0;
    wbytes = 1 << s;
    if (a == 4'h0 && (r || w)) begin
      len = m_len(m_key);
      if (r)
        for (int j = 0; j < wbytes; j++)
          if (m_cur + j < len) e[8*j +: 8] = m_byte(m_key, m_cur + j);
      if (w && m_key == 3)
        for (int j = 0; j < wbytes; j++)
          if (m_cur + j < len) m_mem[m_cur + j] = d[8*j +: 8];
      if (len > 0 && (r || (w && m_key == 3)))
        m_cur = (m_cur + wbytes > len) ? len : m_cur + wbytes;
    end else if (a == 4'h8 && w && s == 2'd1) begin
      m_key = {d[7:0], d[15:8]};
      m_cur = 0;
    end
    exp_q = e;
    tag_q = tag;
  endtask

  task automatic sel(input logic [15:0] k, input string tag);
    cyc(4'h8, 1'b0, 1'b1, 2'd1, {48'h0, k[7:0], k[15:8]}, tag);
  endtask
  task automatic rd(input logic [1:0] s, input string tag);
    cyc(4'h0, 1'b1, 1'b0, s, 64'h0, tag);
  endtask
  task automatic wr(input logic [1:0] s, input logic [63:0] d, input string tag);
    cyc(4'h0, 1'b0, 1'b1, s, d, tag);
  endtask
  task automatic idle();
    cyc(4'h0, 1'b0, 1'b0, 2'd0, 64'h0, "R11");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset", bus_rdata, 64'h0);

    // R1 / R5: default key after reset is the identifier
    rd(2'd2, "R5 default key");
    rd(2'd0, "R4 past end");
    idle();
    // R1 / R5: explicit select, byte reads
    sel(16'h0000, "R1");
    for (int i = 0; i < 5; i++) rd(2'd0, "R5 bytes");
    // R6
    sel(16'h0001, "R1");
    rd(2'd3, "R6 revision");
    // R7: mixed widths, end straddled
    sel(16'h0002, "R1");
    rd(2'd1, "R3 half");
    rd(2'd0, "R3 byte");
    rd(2'd3, "R7 dbl");
    rd(2'd2, "R4 straddle");
    rd(2'd2, "R4 after end");
    // R1: big-endian key order -> 0x0200 unknown
    sel(16'h0200, "R1 key order");
    rd(2'd3, "R4 unknown");
    cyc(4'h8, 1'b0, 1'b1, 2'd1, {48'h0, 8'h02, 8'h00}, "R1 lsb high");
    rd(2'd2, "R1 key 0x0002");
    // R1: byte-size selector write ignored
    cyc(4'h8, 1'b0, 1'b1, 2'd0, 64'h0000_0000_0000_0100, "R1 bad size");
    rd(2'd0, "R1 key kept");
    // R9: write to read-only blob, cursor unchanged
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    rd(2'd1, "R9 cursor held");
    // R2: nonzero offsets and selector reads
    cyc(4'h3, 1'b1, 1'b0, 2'd0, 64'h0, "R2 offset read");
    cyc(4'h8, 1'b1, 1'b0, 2'd1, 64'h0, "R2 sel read");
    cyc(4'h9, 1'b0, 1'b1, 2'd0, 64'h0, "R2 ofs9 write");
    rd(2'd0, "R2 cursor held");
    // R8: writable item
    sel(16'h0003, "R1");
    rd(2'd3, "R8 reset clear");
    sel(16'h0003, "R1");
    wr(2'd3, 64'h8877_6655_4433_2211, "R8");
    cyc(4'h5, 1'b0, 1'b1, 2'd2, 64'hDEAD_BEEF, "R2 ofs5 write");
    wr(2'd2, 64'h0000_0000_CCBB_AA99, "R8");
    wr(2'd1, 64'h0000_0000_0000_EEDD, "R8");
    wr(2'd0, 64'h0000_0000_0000_00F0, "R8");
    wr(2'd3, 64'h1234_5678_9ABC_DEF0, "R8 straddle");
    wr(2'd0, 64'h0000_0000_0000_0055, "R4 write past end");
    sel(16'h0003, "R1");
    rd(2'd3, "R8 readback");
    rd(2'd3, "R8 readback");
    rd(2'd0, "R4 end");
    // R10: simultaneous read and write
    sel(16'h0003, "R1");
    cyc(4'h0, 1'b1, 1'b1, 2'd2, 64'h0000_0000_A1A2_A3A4, "R10");
    cyc(4'h0, 1'b1, 1'b1, 2'd3, 64'hB1B2_B3B4_B5B6_B7B8, "R10");
    cyc(4'h0, 1'b1, 1'b1, 2'd3, 64'hC1C2_C3C4_C5C6_C7C8, "R10 straddle");
    sel(16'h0003, "R1");
    rd(2'd3, "R10 readback");
    rd(2'd3, "R10 readback");
    // R9: write to unknown key
    sel(16'h0007, "R1");
    wr(2'd3, 64'h1, "R9 unknown");
    rd(2'd3, "R4 unknown");
    idle();
    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule